// File: doc/BRIEF.md
# Chip-Select Output Controller

This block owns a row of general-purpose output pins, eight by default, any of which can serve as a serial-bus chip select. Each pin has one stored output bit. A per-pin configuration bit inverts the pin, and a second per-pin bit puts the pin in chip-select mode. In that mode the pin shows its stored bit only while the serial engine marks a frame as active. Outside a frame it rests at its inactive level, which is logic 1 before inversion.

The stored bits are changed only through a write-only force word. The upper half of the word holds set commands and the lower half holds clear commands. Software can therefore raise or drop any subset of pins in one write, with no read-modify-write. A read port returns either the configuration word or a status word that shows the live pin levels.

Top module: `csOutCtrl`

## Requirements
- R1: After reset every stored bit is 1 and every configuration bit is 0. The pins therefore read all ones, and the configuration readback is 0.
- R2: A force write (wrAddr=1) with bit NUM_OUT+n set drives stored bit n to 1.
- R3: A force write with bit n set drives stored bit n to 0.
- R4: In a force write, an output whose set bit and clear bit are both 0 keeps its stored value.
- R5: If one force write both sets and clears the same output, the clear wins and the stored bit becomes 0.
- R6: Configuration bit n (the invert enable) makes pin n equal stored bit n XOR 1. With it at 0, the pin equals the stored bit.
- R7: Configuration bit NUM_OUT+n (chip-select mode) makes pin n rest at 1 XOR invert while frameActive is 0. While frameActive is 1 the pin follows stored bit n XOR invert.
- R8: After a configuration write (wrAddr=0) of 0, every pin equals its stored bit whatever frameActive is.
- R9: With rdSel=1, rdData holds the pin levels in its low NUM_OUT bits and zeros above them. With rdSel=0, rdData holds the configuration word.
- R10: A configuration write leaves the stored bits unchanged. A force write leaves the configuration unchanged.
- R11: A write takes effect on the pins in the cycle after the clock edge that samples it. frameActive acts on the pins combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 1 | 0 selects the configuration word, 1 the force word |
| wrData | input | 2*NUM_OUT | Write data |
| frameActive | input | 1 | High while the serial engine runs a frame |
| rdSel | input | 1 | 0 reads configuration, 1 reads status |
| rdData | output | 2*NUM_OUT | Read data |
| pinOut | output | NUM_OUT | Pin levels |

## Verification
The bench targets force words that set and clear the same pin. A design that let the set win would leave such a pin at 1. It also writes force words with all-zero halves, which would expose a design that cleared bits not named in the write. Chip-select pins are toggled with frameActive both low and high. A gating error would show as a pin that leaks its stored value outside a frame, or one that ignores inversion while idle. Random mixes of configuration and force writes catch a write to one word that corrupts the other, and a status readback that is shifted or stale.

// File: rtl/csOutPkg.sv
package csOutPkg;
  localparam int DEF_NUM_OUT = 8;

  typedef struct packed {
    logic cfgWr;
    logic forceWr;
  } csStrobe_t;
endpackage

// File: rtl/csOutCtl.sv
module csOutCtl
  import csOutPkg::*;
(
  input  logic      wrEn,
  input  logic      wrAddr,
  output csStrobe_t strobe
);
  always_comb begin
    strobe.cfgWr   = wrEn && !wrAddr;
    strobe.forceWr = wrEn && wrAddr;
  end
endmodule

// File: rtl/csOutDp.sv
module csOutDp
  import csOutPkg::*;
#(
  parameter int NUM_OUT = DEF_NUM_OUT,
  localparam int DATA_W = 2 * NUM_OUT
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameActive,
  output logic [NUM_OUT-1:0] storedQ,
  output logic [DATA_W-1:0]  cfgQ,
  output logic [NUM_OUT-1:0] pinOut
);
  logic [NUM_OUT-1:0] storedNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (strobe.cfgWr) cfgQ <= wrData;
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : gPin
    logic setCmd, clrCmd, csMode, invEn, gated;
    assign setCmd = wrData[NUM_OUT + n];
    assign clrCmd = wrData[n];
    assign csMode = cfgQ[NUM_OUT + n];
    assign invEn  = cfgQ[n];

    always_comb begin
      storedNext[n] = storedQ[n];
      if (strobe.forceWr) begin
        if (clrCmd)      storedNext[n] = 1'b0;
        else if (setCmd) storedNext[n] = 1'b1;
      end
    end

    assign gated     = (csMode && !frameActive) ? 1'b1 : storedQ[n];
    assign pinOut[n] = gated ^ invEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) storedQ <= '1;
    else storedQ <= storedNext;
  end
endmodule

// File: rtl/csOutCtrl.sv
module csOutCtrl
  import csOutPkg::*;
#(
  parameter int NUM_OUT = DEF_NUM_OUT,
  localparam int DATA_W = 2 * NUM_OUT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameActive,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_OUT-1:0] pinOut
);
  csStrobe_t strobe;
  logic [NUM_OUT-1:0] storedQ;
  logic [DATA_W-1:0]  cfgQ;

  csOutCtl uCtl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  csOutDp #(.NUM_OUT(NUM_OUT)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .frameActive (frameActive),
    .storedQ     (storedQ),
    .cfgQ        (cfgQ),
    .pinOut      (pinOut)
  );

  assign rdData = rdSel ? {{NUM_OUT{1'b0}}, pinOut} : cfgQ;
endmodule

// File: rtl/csOutChk.sv
module csOutChk #(
  parameter int NUM_OUT = 8,
  localparam int DATA_W = 2 * NUM_OUT
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              frameActive,
  input logic              rdSel,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_OUT-1:0] pinOut,
  input logic [NUM_OUT-1:0] storedQ,
  input logic [DATA_W-1:0]  cfgQ
);
  wire [NUM_OUT-1:0] setPart = wrData[DATA_W-1:NUM_OUT];
  wire [NUM_OUT-1:0] clrPart = wrData[NUM_OUT-1:0];

  AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> ((storedQ & $past(setPart & ~clrPart)) == $past(setPart & ~clrPart))); // R2

  AST_FORCE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> ((storedQ & $past(clrPart)) == '0)); // R3

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr && ((setPart & clrPart) != '0)) |=> ((storedQ & $past(setPart & clrPart)) == '0)); // R5

  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> (((storedQ ^ $past(storedQ)) & ~$past(setPart | clrPart)) == '0)); // R4

  AST_CFG_KEEPS_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr) |=> $stable(storedQ)); // R10

  AST_FORCE_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> $stable(cfgQ)); // R10

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> (((pinOut ^ cfgQ[NUM_OUT-1:0]) & cfgQ[DATA_W-1:NUM_OUT]) == cfgQ[DATA_W-1:NUM_OUT])); // R7

  AST_PLAIN_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ == '0) |-> (pinOut == storedQ)); // R8

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> (rdData == {{NUM_OUT{1'b0}}, pinOut})); // R9
endmodule

bind csOutCtrl csOutChk #(.NUM_OUT(NUM_OUT)) uChk (.*);

// File: tb/tb_csOutCtrl.sv
module tb_csOutCtrl;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [W-1:0] wrData = '0;
  logic frameActive = 1'b0;
  logic rdSel = 1'b0;
  logic [W-1:0] rdData;
  logic [N-1:0] pinOut;

  int total = 0;
  int bad = 0;
  logic [N-1:0] mStored;
  logic [W-1:0] mCfg;

  always #10 clk = ~clk;

  csOutCtrl #(.NUM_OUT(N)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameActive(frameActive), .rdSel(rdSel), .rdData(rdData), .pinOut(pinOut)
  );

  function automatic logic [N-1:0] expPins(logic [N-1:0] st, logic [W-1:0] cf, logic fa);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic b;
      b = (cf[N+i] && !fa) ? 1'b1 : st[i];
      r[i] = b ^ cf[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] applyForce(logic [N-1:0] st, logic [W-1:0] d);
    logic [N-1:0] r;
    r = st;
    for (int i = 0; i < N; i++) begin
      if (d[i]) r[i] = 1'b0;
      else if (d[N+i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic a, logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    if (a) mStored = applyForce(mStored, d);
    else mCfg = d;
  endtask

  task automatic chkPins(string tag);
    #1;
    chk(tag, {{N{1'b0}}, pinOut}, {{N{1'b0}}, expPins(mStored, mCfg, frameActive)});
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mStored = '1;
    mCfg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pins", {{N{1'b0}}, pinOut}, {{N{1'b0}}, {N{1'b1}}});
    rdSel = 1'b0; #1;
    chk("R1 cfg", rdData, '0);

    // R3: clear pins 0 and 5 (bits 0 and 5)
    doWrite(1'b1, 16'h0021);
    chkPins("R3 clear");
    // R4: empty force word changes nothing
    doWrite(1'b1, 16'h0000);
    chkPins("R4 hold");
    // R2: set pin 0 via bit 8
    doWrite(1'b1, 16'h0100);
    chkPins("R2 set");
    // R5: set and clear pin 3 together, clear wins
    doWrite(1'b1, 16'h0808);
    chk("R5 clr wins", {{N{1'b0}}, pinOut}, {{N{1'b0}}, mStored});
    chk("R5 bit3", {15'd0, pinOut[3]}, '0);
    // R11: pin changes only after the sampling edge
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 1'b1; wrData = 16'h0002;
    #1;
    chk("R11 before edge", {{N{1'b0}}, pinOut}, {{N{1'b0}}, expPins(mStored, mCfg, frameActive)});
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    mStored = applyForce(mStored, 16'h0002);
    chkPins("R11 after edge");
    // R6: invert pins 0..3
    doWrite(1'b0, 16'h000F);
    chkPins("R6 invert");
    chk("R10 stored kept", {{N{1'b0}}, pinOut ^ 8'h0F}, {{N{1'b0}}, mStored});
    // R7: chip-select mode on pins 4..7, pin 4 inverted, frame idle
    doWrite(1'b0, 16'hF010);
    frameActive = 1'b0;
    chkPins("R7 idle");
    frameActive = 1'b1;
    chkPins("R7 active");
    // R9 status and config readback
    rdSel = 1'b1; #1;
    chk("R9 status", rdData, {{N{1'b0}}, pinOut});
    rdSel = 1'b0; #1;
    chk("R9 cfg", rdData, mCfg);
    // R10: force write leaves config
    doWrite(1'b1, 16'hFF00);
    #1;
    chk("R10 cfg kept", rdData, mCfg);
    // R8: config zero gives plain outputs
    doWrite(1'b0, 16'h0000);
    frameActive = 1'b0;
    chkPins("R8 plain idle");
    chk("R8 all set", {{N{1'b0}}, pinOut}, {{N{1'b0}}, {N{1'b1}}});

    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      frameActive = 1'($urandom);
      rdSel = 1'($urandom);
      if ($urandom % 4 == 0) doWrite(1'b0, d);
      else doWrite(1'b1, d);
      #1;
      chk("R2/R3/R5/R6/R7 random pins", {{N{1'b0}}, pinOut},
          {{N{1'b0}}, expPins(mStored, mCfg, frameActive)});
      chk("R9 random read", rdData,
          rdSel ? {{N{1'b0}}, expPins(mStored, mCfg, frameActive)} : mCfg);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule